// File: doc/BRIEF.md
# Descriptor Flow Decision Unit

This unit decides, at the moment a descriptor finishes, what the channel does next. A descriptor's command word carries three 2-bit control fields: one for raising an interrupt, one for branching and one for holding the channel. Each field selects one of four modes: never, when a condition is met, when it is not met, or unconditionally. Each field has its own condition. That condition is a masked compare of the low four device-status bits against a mask and a value held in the function's own select word.

When the completion strobe arrives, the unit samples the command bits, the device status, the three select words, the current command pointer and the descriptor's branch address in a single snapshot. One cycle later it presents the results together:

- an interrupt pulse,
- a hold (wait) indication,
- a branch decision with the next command pointer,
- one-cycle requests telling the register unit to set or clear its branch-taken status bit,
- an advance pulse.

A held descriptor produces no interrupt, no branch-taken update and no advance. Its pointer stays put so that the same descriptor can be evaluated again later.

Top module: `cond_flow_unit`

## Requirements
- R1: After synchronous active-low reset, every output is zero, including `next_ptr_o`.
- R2: A function's condition is true when `(dev_stat_i[3:0] & mask) == (value & mask)`. The mask is bits 19:16 of its select word and the value is bits 3:0. Device-status bits 7:4 and the other select bits have no effect.
- R3: Each 2-bit control field is decoded as follows: 0 = never, 1 = when the condition is true, 2 = when the condition is false, 3 = always.
- R4: The interrupt field is `ctrl_i[5:4]` and uses `irq_sel_i`. When it fires at a strobe, `irq_o` is high for exactly the one cycle after that strobe.
- R5: The branch field is `ctrl_i[3:2]` and uses `br_sel_i`. A taken branch sets `br_take_o`, loads `next_ptr_o` with `br_addr_i` and pulses `bt_set_o` for one cycle.
- R6: A branch that is not taken loads `next_ptr_o` with `cur_ptr_i + 16` and pulses `bt_clr_o` for one cycle.
- R7: The wait field is `ctrl_i[1:0]` and uses `wait_sel_i`. When it fires, `wait_o` is high, `irq_o`, `bt_set_o`, `bt_clr_o`, `adv_o` and `br_take_o` stay low, and `next_ptr_o` equals `cur_ptr_i`.
- R8: Each function is evaluated only against its own select word. A match in one select word does not affect the other two functions.
- R9: `res_vld_o` pulses exactly in the cycle after each strobe. `adv_o` pulses with it when the descriptor is not held. Without a strobe, no pulse output is raised.
- R10: All results come from the snapshot taken at the strobe. `wait_o`, `br_take_o` and `next_ptr_o` hold their values until the next strobe, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_i | input | 1 | Descriptor completion strobe |
| ctrl_i | input | 6 | Command control bits: interrupt 5:4, branch 3:2, wait 1:0 |
| dev_stat_i | input | 8 | Device status bits (low 4 used) |
| irq_sel_i | input | 32 | Interrupt select word (mask 19:16, value 3:0) |
| br_sel_i | input | 32 | Branch select word |
| wait_sel_i | input | 32 | Wait select word |
| cur_ptr_i | input | PTR_W | Current command pointer |
| br_addr_i | input | PTR_W | Branch target from the descriptor |
| res_vld_o | output | 1 | Result-valid pulse, one cycle after the strobe |
| wait_o | output | 1 | Descriptor is held |
| irq_o | output | 1 | Interrupt pulse |
| adv_o | output | 1 | Pointer-advance pulse |
| br_take_o | output | 1 | Branch taken |
| bt_set_o | output | 1 | Request to set the branch-taken status bit |
| bt_clr_o | output | 1 | Request to clear the branch-taken status bit |
| next_ptr_o | output | PTR_W | Next command pointer |

## Verification
The assertions check on every cycle that:
- a result-valid pulse follows each strobe and only a strobe,
- a held descriptor suppresses every side effect,
- the two branch-taken requests never occur together,
- a non-taken branch points 16 bytes past the snapshot pointer,
- the held outputs stay stable between strobes.

Only the bench scenarios can show that the masked compare and the four-mode decode give the right answer for particular status and select patterns. They also show that each function reads its own select word and that ignored status bits really have no effect.

// File: rtl/cfu_pkg.sv
// Shared types and constants for the descriptor flow decision unit.
// Assumes 2-bit control fields and 4-bit mask/value fields in the select word.
package cfu_pkg;
    typedef enum logic [1:0] {
        MODE_NEVER    = 2'd0,
        MODE_IF_MATCH = 2'd1,
        MODE_IF_MISS  = 2'd2,
        MODE_ALWAYS   = 2'd3
    } cfu_mode_e;

    localparam int COND_W   = 4;   // status bits taking part in the compare
    localparam int MASK_LSB = 16;  // position of the mask inside a select word
    localparam int VAL_LSB  = 0;   // position of the value inside a select word
    localparam int NFUNC    = 3;   // interrupt, branch, wait

    // function slots; slot f owns ctrl bits [2*(NFUNC-1-f)+1 : 2*(NFUNC-1-f)]
    localparam int F_IRQ  = 0;
    localparam int F_BR   = 1;
    localparam int F_WAIT = 2;
endpackage

// File: rtl/cfu_match.sv
// Masked condition compare: true when the masked status equals the masked value.
// Assumes mask and value already extracted from the select word.
module cfu_match #(
    parameter int COND_W = 4
) (
    input  logic [COND_W-1:0] stat_i,
    input  logic [COND_W-1:0] mask_i,
    input  logic [COND_W-1:0] val_i,
    output logic              hit_o
);
    // compare only the bits the mask enables
    always_comb begin
        hit_o = ((stat_i & mask_i) == (val_i & mask_i));
    end
endmodule

// File: rtl/cfu_resolve.sv
// Turns a 2-bit mode and a condition into a fire decision.
// Assumes the mode encoding of cfu_pkg.
module cfu_resolve
    import cfu_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       hit_i,
    output logic       fire_o
);
    cfu_mode_e mode;

    // decode mode against the condition
    always_comb begin
        mode = cfu_mode_e'(mode_i);
        unique case (mode)
            MODE_NEVER:    fire_o = 1'b0;
            MODE_IF_MATCH: fire_o = hit_i;
            MODE_IF_MISS:  fire_o = !hit_i;
            MODE_ALWAYS:   fire_o = 1'b1;
            default:       fire_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfu_ptr_next.sv
// Selects the next command pointer: hold, branch target, or sequential step.
// Assumes descriptors are DESC_BYTES apart in memory.
module cfu_ptr_next #(
    parameter int PTR_W      = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic             hold_i,
    input  logic             take_i,
    input  logic [PTR_W-1:0] cur_i,
    input  logic [PTR_W-1:0] tgt_i,
    output logic [PTR_W-1:0] next_o
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);

    // priority: hold keeps the pointer, then branch, else step forward
    always_comb begin
        if (hold_i)
            next_o = cur_i;
        else if (take_i)
            next_o = tgt_i;
        else
            next_o = cur_i + STEP;
    end
endmodule

// File: rtl/cond_flow_unit.sv
// Descriptor flow decision unit. On done_i it snapshots the control bits,
// device status, select words and pointers, and one cycle later presents the
// interrupt, wait and branch decisions with the next pointer.
// Assumes done_i is a single-cycle strobe; all outputs are registered.
module cond_flow_unit
    import cfu_pkg::*;
#(
    parameter int PTR_W      = 32,
    parameter int DESC_BYTES = 16,
    parameter int SEL_W      = 32,
    parameter int STAT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [5:0]        ctrl_i,
    input  logic [STAT_W-1:0] dev_stat_i,
    input  logic [SEL_W-1:0]  irq_sel_i,
    input  logic [SEL_W-1:0]  br_sel_i,
    input  logic [SEL_W-1:0]  wait_sel_i,
    input  logic [PTR_W-1:0]  cur_ptr_i,
    input  logic [PTR_W-1:0]  br_addr_i,
    output logic              res_vld_o,
    output logic              wait_o,
    output logic              irq_o,
    output logic              adv_o,
    output logic              br_take_o,
    output logic              bt_set_o,
    output logic              bt_clr_o,
    output logic [PTR_W-1:0]  next_ptr_o
);
    logic [SEL_W-1:0] sel_w [NFUNC];
    logic [NFUNC-1:0] fire;
    logic [PTR_W-1:0] ptr_nxt;

    // gather select words by function slot
    always_comb begin
        sel_w[F_IRQ]  = irq_sel_i;
        sel_w[F_BR]   = br_sel_i;
        sel_w[F_WAIT] = wait_sel_i;
    end

    // one compare and one mode decoder per function
    for (genvar f = 0; f < NFUNC; f++) begin : g_func
        localparam int MLSB = 2 * (NFUNC - 1 - f);
        logic hit;

        cfu_match #(.COND_W(COND_W)) u_match (
            .stat_i (dev_stat_i[COND_W-1:0]),
            .mask_i (sel_w[f][MASK_LSB +: COND_W]),
            .val_i  (sel_w[f][VAL_LSB +: COND_W]),
            .hit_o  (hit)
        );

        cfu_resolve u_res (
            .mode_i (ctrl_i[MLSB +: 2]),
            .hit_i  (hit),
            .fire_o (fire[f])
        );
    end

    cfu_ptr_next #(.PTR_W(PTR_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
        .hold_i (fire[F_WAIT]),
        .take_i (fire[F_BR]),
        .cur_i  (cur_ptr_i),
        .tgt_i  (br_addr_i),
        .next_o (ptr_nxt)
    );

    // held results: update only at the strobe snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_o     <= 1'b0;
            br_take_o  <= 1'b0;
            next_ptr_o <= '0;
        end else if (done_i) begin
            wait_o     <= fire[F_WAIT];
            br_take_o  <= fire[F_BR] && !fire[F_WAIT];
            next_ptr_o <= ptr_nxt;
        end
    end

    // single-cycle pulses following a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld_o <= 1'b0;
            irq_o     <= 1'b0;
            adv_o     <= 1'b0;
            bt_set_o  <= 1'b0;
            bt_clr_o  <= 1'b0;
        end else begin
            res_vld_o <= done_i;
            irq_o     <= done_i && !fire[F_WAIT] && fire[F_IRQ];
            adv_o     <= done_i && !fire[F_WAIT];
            bt_set_o  <= done_i && !fire[F_WAIT] && fire[F_BR];
            bt_clr_o  <= done_i && !fire[F_WAIT] && !fire[F_BR];
        end
    end
endmodule

// File: rtl/cfu_checker.sv
// Property checker for cond_flow_unit, attached by bind below.
// Assumes the same parameters as the unit it watches.
module cfu_checker #(
    parameter int PTR_W      = 32,
    parameter int DESC_BYTES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_i,
    input logic [PTR_W-1:0] cur_ptr_i,
    input logic             res_vld_o,
    input logic             wait_o,
    input logic             irq_o,
    input logic             adv_o,
    input logic             br_take_o,
    input logic             bt_set_o,
    input logic             bt_clr_o,
    input logic [PTR_W-1:0] next_ptr_o
);
    // R9
    vld_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> res_vld_o);
    // R9
    no_vld_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> !res_vld_o && !irq_o && !adv_o && !bt_set_o && !bt_clr_o);
    // R7
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> !irq_o && !adv_o && !bt_set_o && !bt_clr_o && !br_take_o);
    // R5
    bt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bt_set_o && bt_clr_o));
    // R6
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bt_clr_o |-> next_ptr_o == $past(cur_ptr_i) + PTR_W'(DESC_BYTES));
    // R4
    irq_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> res_vld_o);
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(next_ptr_o) && $stable(wait_o) && $stable(br_take_o));
endmodule

bind cond_flow_unit cfu_checker #(.PTR_W(PTR_W), .DESC_BYTES(DESC_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done_i),
    .cur_ptr_i  (cur_ptr_i),
    .res_vld_o  (res_vld_o),
    .wait_o     (wait_o),
    .irq_o      (irq_o),
    .adv_o      (adv_o),
    .br_take_o  (br_take_o),
    .bt_set_o   (bt_set_o),
    .bt_clr_o   (bt_clr_o),
    .next_ptr_o (next_ptr_o)
);

// File: tb/sim_cond_flow_unit.sv
module sim_cond_flow_unit;
    localparam int CLK_PERIOD = 10;
    localparam int PTR_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic done_i = 1'b0;
    logic [5:0] ctrl_i = '0;
    logic [7:0] dev_stat_i = '0;
    logic [31:0] irq_sel_i = '0, br_sel_i = '0, wait_sel_i = '0;
    logic [PTR_W-1:0] cur_ptr_i = '0, br_addr_i = '0;
    logic res_vld_o, wait_o, irq_o, adv_o, br_take_o, bt_set_o, bt_clr_o;
    logic [PTR_W-1:0] next_ptr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_flow_unit u0 (.*);

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit cond_of(input logic [31:0] sel, input logic [7:0] st);
        logic [3:0] m = sel[19:16];
        return (st[3:0] & m) == (sel[3:0] & m);
    endfunction

    function automatic bit dec(input logic [1:0] md, input bit c);
        case (md)
            2'd0: return 1'b0;
            2'd1: return c;
            2'd2: return !c;
            default: return 1'b1;
        endcase
    endfunction

    // drive one strobe at a falling edge, check results one cycle later
    task automatic fire(input string tag, input logic [5:0] ctl, input logic [7:0] st,
                        input logic [31:0] is, input logic [31:0] bs, input logic [31:0] ws,
                        input logic [PTR_W-1:0] cp, input logic [PTR_W-1:0] ba);
        bit ei, eb, ew;
        logic [PTR_W-1:0] ep;
        ei = dec(ctl[5:4], cond_of(is, st));
        eb = dec(ctl[3:2], cond_of(bs, st));
        ew = dec(ctl[1:0], cond_of(ws, st));
        ep = ew ? cp : (eb ? ba : cp + 32'd16);
        ctrl_i = ctl; dev_stat_i = st; irq_sel_i = is; br_sel_i = bs;
        wait_sel_i = ws; cur_ptr_i = cp; br_addr_i = ba; done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        chk(tag, "res_vld", res_vld_o, 1);
        chk(tag, "wait", wait_o, ew);
        chk(tag, "irq", irq_o, ei && !ew);
        chk(tag, "adv", adv_o, !ew);
        chk(tag, "br_take", br_take_o, eb && !ew);
        chk(tag, "bt_set", bt_set_o, eb && !ew);
        chk(tag, "bt_clr", bt_clr_o, !eb && !ew);
        chk(tag, "next_ptr", next_ptr_o, ep);
        @(negedge clk);
        chk(tag, "irq_one_cycle", irq_o, 0);
        chk(tag, "vld_one_cycle", res_vld_o, 0);
    endtask

    task automatic t_reset;
        chk("R1", "res_vld", res_vld_o, 0);
        chk("R1", "wait", wait_o, 0);
        chk("R1", "irq", irq_o, 0);
        chk("R1", "br_take", br_take_o, 0);
        chk("R1", "bt_pulses", {bt_set_o, bt_clr_o, adv_o}, 0);
        chk("R1", "next_ptr", next_ptr_o, 0);
    endtask

    // R3 / R4: every interrupt mode against a match and a miss
    task automatic t_irq_modes;
        for (int md = 0; md < 4; md++) begin
            fire("R3_R4", {md[1:0], 4'b0000}, 8'h05, 32'h000F_0005, 0, 0, 32'h100, 32'h800);
            fire("R3_R4", {md[1:0], 4'b0000}, 8'h06, 32'h000F_0005, 0, 0, 32'h100, 32'h800);
        end
    endtask

    // R2: mask selects bits, upper status bits ignored, other select bits ignored
    task automatic t_compare;
        fire("R2", 6'b01_00_00, 8'hF3, 32'h0003_0003, 0, 0, 32'h40, 0);
        chk("R2", "upper_stat_ignored", irq_o, 0); // pulse already ended; see next
        fire("R2", 6'b01_00_00, 8'hA9, 32'hFFF8_FFF8, 0, 0, 32'h40, 0);
        fire("R2", 6'b01_00_00, 8'h01, 32'h0004_0004, 0, 0, 32'h40, 0);
        fire("R2", 6'b01_00_00, 8'h0E, 32'h0000_000B, 0, 0, 32'h40, 0);
    endtask

    task automatic t_branch;
        fire("R5", 6'b00_01_00, 8'h02, 0, 32'h0002_0002, 0, 32'h200, 32'hABC0); // R5 taken
        fire("R5", 6'b00_11_00, 8'h00, 0, 0, 0, 32'h200, 32'h1230);
        fire("R6", 6'b00_01_00, 8'h00, 0, 32'h0002_0002, 0, 32'h200, 32'hABC0); // R6 not taken
        fire("R6", 6'b00_00_00, 8'h00, 0, 0, 0, 32'hFFFF_FFF0, 32'h10);
    endtask

    task automatic t_wait;
        fire("R7", 6'b11_11_11, 8'h00, 0, 0, 0, 32'h300, 32'h900);
        fire("R7", 6'b11_11_10, 8'h01, 0, 0, 32'h0001_0000, 32'h300, 32'h900);
        fire("R7", 6'b11_11_01, 8'h01, 0, 0, 32'h0001_0000, 32'h300, 32'h900); // not held
    endtask

    // R8: irq select matches, branch and wait selects miss
    task automatic t_separation;
        fire("R8", 6'b01_01_01, 8'h03, 32'h000F_0003, 32'h000F_0004, 32'h000F_0008,
             32'h500, 32'h700);
        fire("R8", 6'b01_01_01, 8'h03, 32'h000F_0001, 32'h000F_0003, 32'h000F_0008,
             32'h500, 32'h700);
    endtask

    // R9 / R10: no strobe, inputs change, held results stay
    task automatic t_snapshot;
        logic [PTR_W-1:0] p;
        fire("R10", 6'b00_11_00, 8'h00, 0, 0, 0, 32'h600, 32'h4440);
        p = next_ptr_o;
        ctrl_i = 6'b11_00_11; cur_ptr_i = 32'h1; br_addr_i = 32'h2; dev_stat_i = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R10", "next_ptr_held", next_ptr_o, p);
        chk("R10", "br_take_held", br_take_o, 1);
        chk("R10", "wait_held", wait_o, 0);
        chk("R9", "no_pulses", {res_vld_o, irq_o, adv_o, bt_set_o, bt_clr_o}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_irq_modes();
        t_compare();
        t_branch();
        t_wait();
        t_separation();
        t_snapshot();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule